// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port for a chip's boundary-scan logic. A tester drives a serial clock, a mode-select line and serial data in, and reads serial data back. The block walks the sixteen-state test controller, holds a six-bit instruction, and decodes it into the data register to route between the instruction input and the serial output. It also drives the pin-control and core-reset lines that the current instruction calls for.

Four data paths can be selected: a one-bit bypass cell, a 32-bit identification word, a small test-control register owned by the block, and an external boundary-cell chain. The chain is reached through capture, shift and update strobes, a serial output toward the chain and a serial return from it. No part of this block streams data, so every pin is a plain level or strobe and nothing uses valid/ready handshaking. Every register changes on the rising test clock. Serial output changes on the falling test clock.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is held in Test-Logic-Reset. The instruction is IDCODE (011101), `tdo_oe` and `tdo` are 0, `tctl_q` is 0, and `pin_force`, `pin_hiz` and `core_rst` are 0.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. The edge that enters that state reloads IDCODE and clears `tctl_q`. After only four such edges from Shift-DR, the old instruction still applies.
- R3: State changes follow the standard sixteen-state test controller graph, driven by `tms` on each rising `tck` edge.
- R4: Capture-IR loads 000001 into the instruction shifter. Shift-IR moves it out least significant bit first, so the first six `tdo` bits read 1,0,0,0,0,0.
- R5: A shifted instruction takes effect only on the rising edge that leaves Update-IR. Until then, the decoded outputs keep the previous instruction.
- R6: `tdo` and `tdo_oe` change only on the falling `tck` edge. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR. `tdo` is 0 whenever it is not enabled.
- R7: IDCODE (011101) selects a 32-bit register that captures `ID_VALUE` and shifts it out least significant bit first.
- R8: BYPASS (111111), and every code not listed in R7, R9, R10 and R11, selects a one-bit cell that captures 0. This covers the codes for unsupported leakage-test and lockout-recovery instructions.
- R9: EXTEST (000000) selects the boundary chain and raises `pin_force` and `core_rst`. SAMPLE/PRELOAD (000001) selects the boundary chain with all three pin and reset controls low.
- R10: CLAMP (011111) selects bypass and raises `pin_force` and `core_rst`. HIGHZ (111101) selects bypass and raises `pin_hiz` and `core_rst` with `pin_force` low.
- R11: ENABLE (000010) selects the `TCTL_W`-bit test-control register. Capture-DR loads the present `tctl_q`, and the edge leaving Update-DR copies the shifted value to `tctl_q`.
- R12: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR while EXTEST or SAMPLE/PRELOAD is in effect. `bsr_tdi` follows `tdi`, and `tdo` in Shift-DR returns `bsr_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Boundary chain parallel capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_tdi | output | 1 | Serial data toward the boundary chain |
| bsr_so | input | 1 | Serial data returned from the boundary chain |
| pin_force | output | 1 | Output pins take values from the boundary cells |
| pin_hiz | output | 1 | All output pins tri-stated |
| core_rst | output | 1 | Functional core held in reset |
| tctl_q | output | TCTL_W | Test-control register contents |

## Verification
Every instruction is loaded through the serial port and then driven with distinct data patterns. This separates routing errors between registers of different lengths. A one-bit bypass shows up as a single-cycle delay, the identity word and boundary capture pattern as fixed words, and the test-control register as the data it was given. The controller is driven through both Pause states, through exits taken straight from Capture states, and through `tms`-high runs of four and five edges. These runs separate a correct reset return from one that comes an edge late or early. An asynchronous reset while a core-resetting instruction is active, and the unlisted codes 101010 and 000011, show that decode falls back to bypass. A reference model of the controller is compared against the design on every clock.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 6;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 6'b000001;
  localparam logic [IR_W-1:0] OP_ENABLE = 6'b000010;
  localparam logic [IR_W-1:0] OP_IDCODE = 6'b011101;
  localparam logic [IR_W-1:0] OP_CLAMP  = 6'b011111;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 6'b111101;
  localparam logic [IR_W-1:0] OP_BYPASS = 6'b111111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR, DR_TCTL} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    force_pins;
    logic    hiz;
    logic    core_rst;
  } ir_dec_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st,
  output tap_state_e st_nxt
);

  always_comb begin
    unique case (st)
      ST_TLR:    st_nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   st_nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= st_nxt;
  end

  // Run length of tms-high edges, saturating at five, for the reset-return check.
  logic [2:0] ones_cnt;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ones_cnt <= '0;
    else if (!tms)            ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  assert_five_ones_tlr_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && ones_cnt >= 3'd4) |=> (st == ST_TLR));

  assert_tlr_leave_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR && !tms) |=> (st == ST_RTI));

  assert_shift_ir_path_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_IR && !tms) |=> (st == ST_SH_IR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      st,
  input  tap_state_e      st_nxt,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q,
  output ir_dec_t         dec
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (st == ST_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (st == ST_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                ir_q <= OP_IDCODE;
    else if (st_nxt == ST_TLR)  ir_q <= OP_IDCODE;
    else if (st == ST_UPD_IR)   ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  always_comb begin
    dec = '0;
    dec.sel = DR_BYP;
    case (ir_q)
      OP_EXTEST: begin dec.sel = DR_BSR; dec.force_pins = 1'b1; dec.core_rst = 1'b1; end
      OP_SAMPLE: dec.sel = DR_BSR;
      OP_IDCODE: dec.sel = DR_ID;
      OP_ENABLE: dec.sel = DR_TCTL;
      OP_CLAMP:  begin dec.force_pins = 1'b1; dec.core_rst = 1'b1; end
      OP_HIGHZ:  begin dec.hiz = 1'b1; dec.core_rst = 1'b1; end
      default:   dec.sel = DR_BYP;
    endcase
  end

  assert_capture_pattern_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  assert_ir_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UPD_IR && st_nxt != ST_TLR) |=> $stable(ir_q));

  assert_hiz_resets_R10: assert property (@(posedge tck) disable iff (!trst_n)
    dec.hiz |-> (dec.core_rst && !dec.force_pins));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1A5C_E01D,
  parameter int          TCTL_W   = 8
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        st,
  input  tap_state_e        st_nxt,
  input  dr_sel_e           sel,
  input  logic              bsr_so,
  output logic              dr_so,
  output logic              bsr_capture,
  output logic              bsr_shift,
  output logic              bsr_update,
  output logic [TCTL_W-1:0] tctl_q
);

  localparam int ID_W = 32;

  logic              byp_sr;
  logic [ID_W-1:0]   id_sr;
  logic [TCTL_W-1:0] tctl_sr;
  logic              cap, sh, upd;

  assign cap = (st == ST_CAP_DR);
  assign sh  = (st == ST_SH_DR);
  assign upd = (st == ST_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_sr <= 1'b0;
    end else if (sel == DR_BYP) begin
      if (cap)     byp_sr <= 1'b0;
      else if (sh) byp_sr <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_VALUE;
    end else if (sel == DR_ID) begin
      if (cap)     id_sr <= ID_VALUE;
      else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  generate
    if (TCTL_W == 1) begin : g_tctl_one
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  tctl_sr <= '0;
        else if (sel == DR_TCTL) begin
          if (cap)     tctl_sr <= tctl_q;
          else if (sh) tctl_sr <= tdi;
        end
      end
    end else begin : g_tctl_wide
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  tctl_sr <= '0;
        else if (sel == DR_TCTL) begin
          if (cap)     tctl_sr <= tctl_q;
          else if (sh) tctl_sr <= {tdi, tctl_sr[TCTL_W-1:1]};
        end
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      tctl_q <= '0;
    else if (st_nxt == ST_TLR)        tctl_q <= '0;
    else if (upd && sel == DR_TCTL)   tctl_q <= tctl_sr;
  end

  assign bsr_capture = cap && (sel == DR_BSR);
  assign bsr_shift   = sh  && (sel == DR_BSR);
  assign bsr_update  = upd && (sel == DR_BSR);

  always_comb begin
    unique case (sel)
      DR_BYP:  dr_so = byp_sr;
      DR_ID:   dr_so = id_sr[0];
      DR_BSR:  dr_so = bsr_so;
      DR_TCTL: dr_so = tctl_sr[0];
      default: dr_so = byp_sr;
    endcase
  end

  assert_tctl_hold_R11: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd && sel == DR_TCTL) && (st_nxt != ST_TLR) |=> $stable(tctl_q));

  assert_bsr_strobe_sel_R12: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> (sel == DR_BSR));

  assert_bsr_onehot_R12: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1A5C_E01D,
  parameter int          TCTL_W   = 8
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              bsr_capture,
  output logic              bsr_shift,
  output logic              bsr_update,
  output logic              bsr_tdi,
  input  logic              bsr_so,
  output logic              pin_force,
  output logic              pin_hiz,
  output logic              core_rst,
  output logic [TCTL_W-1:0] tctl_q
);

  tap_state_e      st, st_nxt;
  ir_dec_t         dec;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, dr_so;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .st_nxt(st_nxt)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .st_nxt(st_nxt),
    .ir_so(ir_so), .ir_q(ir_q), .dec(dec)
  );

  tap_dr #(.ID_VALUE(ID_VALUE), .TCTL_W(TCTL_W)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .st_nxt(st_nxt),
    .sel(dec.sel), .bsr_so(bsr_so), .dr_so(dr_so),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .tctl_q(tctl_q)
  );

  assign bsr_tdi   = tdi;
  assign pin_force = dec.force_pins;
  assign pin_hiz   = dec.hiz;
  assign core_rst  = dec.core_rst;

  // Serial output is retimed to the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == ST_SH_IR) || (st == ST_SH_DR);
      if (st == ST_SH_IR)      tdo <= ir_so;
      else if (st == ST_SH_DR) tdo <= dr_so;
      else                     tdo <= 1'b0;
    end
  end

  assert_oe_shift_R6: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((st == ST_SH_IR) || (st == ST_SH_DR)));

  assert_tdo_quiet_R6: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);

  assert_ir_known_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !$isunknown(ir_q));

endmodule

// File: tb/sim_tap_ctrl.sv
module sim_tap_ctrl;

  localparam logic [31:0] IDV  = 32'h1A5C_E01D;
  localparam int          TW   = 8;
  localparam int          BL   = 12;
  localparam logic [BL-1:0] BPAT = 12'hC35;

  localparam logic [5:0] C_EXT = 6'b000000, C_SMP = 6'b000001, C_ENA = 6'b000010;
  localparam logic [5:0] C_IDC = 6'b011101, C_CLP = 6'b011111, C_HIZ = 6'b111101;
  localparam logic [5:0] C_BYP = 6'b111111;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_tdi, bsr_so;
  logic pin_force, pin_hiz, core_rst;
  logic [TW-1:0] tctl_q;
  logic [BL-1:0] chain;

  always #4 tck = ~tck;

  tap_ctrl #(.ID_VALUE(IDV), .TCTL_W(TW)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bsr_tdi(bsr_tdi), .bsr_so(bsr_so), .pin_force(pin_force), .pin_hiz(pin_hiz),
    .core_rst(core_rst), .tctl_q(tctl_q)
  );

  // External boundary chain stand-in.
  always @(posedge tck or negedge trst_n) begin
    if (!trst_n)          chain <= '0;
    else if (bsr_capture) chain <= BPAT;
    else if (bsr_shift)   chain <= {bsr_tdi, chain[BL-1:1]};
  end
  assign bsr_so = chain[0];

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: 0 TLR 1 RTI 2 SelDR 3 CapDR 4 ShDR 5 Ex1DR 6 PauDR 7 Ex2DR 8 UpdDR
  // 9 SelIR 10 CapIR 11 ShIR 12 Ex1IR 13 PauIR 14 Ex2IR 15 UpdIR
  int ms = 0;
  logic [5:0] mir = C_IDC, mirsr = 6'b000001;
  logic [31:0] mdr = '0;
  int mlen = 1;
  logic [TW-1:0] mtctl = '0;
  logic last_tdo;
  logic pre_rst;

  function automatic int nxt(int s, logic t);
    int tbl1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int tbl0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    return t ? tbl1[s] : tbl0[s];
  endfunction

  function automatic bit m_bsr();  return mir == C_EXT || mir == C_SMP; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic e_oe, e_tdo;
    e_oe  = (ms == 4 || ms == 11);
    e_tdo = (ms == 11) ? mirsr[0] : (ms == 4) ? mdr[0] : 1'b0;
    chk("R3 R6 tdo_oe", 32'(tdo_oe), 32'(e_oe));
    chk("R6 tdo", 32'(tdo), 32'(e_tdo));
    chk("R9 pin_force", 32'(pin_force), 32'(mir == C_EXT || mir == C_CLP));
    chk("R10 pin_hiz", 32'(pin_hiz), 32'(mir == C_HIZ));
    chk("R10 core_rst", 32'(core_rst), 32'(mir == C_EXT || mir == C_CLP || mir == C_HIZ));
    chk("R12 bsr strobes", {29'd0, bsr_capture, bsr_shift, bsr_update},
        {29'd0, m_bsr() && ms == 3, m_bsr() && ms == 4, m_bsr() && ms == 8});
    chk("R11 tctl_q", 32'(tctl_q), 32'(mtctl));
  endtask

  task automatic model_edge(logic t, logic d);
    case (ms)
      10: mirsr = 6'b000001;
      11: mirsr = {d, mirsr[5:1]};
      15: mir = mirsr;
      3: begin
        if (m_bsr())          begin mdr = 32'(BPAT); mlen = BL; end
        else if (mir == C_IDC) begin mdr = IDV; mlen = 32; end
        else if (mir == C_ENA) begin mdr = 32'(mtctl); mlen = TW; end
        else                   begin mdr = '0; mlen = 1; end
      end
      4: begin mdr = mdr >> 1; mdr[mlen-1] = d; end
      8: if (mir == C_ENA) mtctl = mdr[TW-1:0];
      default: ;
    endcase
    ms = nxt(ms, t);
    if (ms == 0) begin mir = C_IDC; mtctl = '0; end
  endtask

  task automatic step(logic t, logic d);
    tms = t; tdi = d;
    @(posedge tck);
    model_edge(t, d);
    @(negedge tck); #1;
    compare_all();
    last_tdo = tdo;
  endtask

  // From Run-Test/Idle: load an instruction, return the captured bits, end in Run-Test/Idle.
  task automatic load_ir(logic [5:0] code, output logic [5:0] rd);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    rd[0] = last_tdo;
    for (int i = 0; i < 6; i++) begin
      step(i == 5, code[i]);
      if (i < 5) rd[i+1] = last_tdo;
    end
    step(1, 0);
    pre_rst = core_rst;
    step(0, 0);
  endtask

  task automatic shift_dr(int n, logic [31:0] data, output logic [31:0] rd);
    rd = '0;
    step(1, 0); step(0, 0); step(0, 0);
    rd[0] = last_tdo;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, data[i]);
      if (i < n - 1) rd[i+1] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic do_trst();
    @(negedge tck); #1;
    trst_n = 1'b0; tms = 1'b1;
    #2;
    ms = 0; mir = C_IDC; mtctl = '0;
    chk("R1 tdo_oe in reset", 32'(tdo_oe), 32'd0);
    chk("R1 core_rst in reset", 32'(core_rst), 32'd0);
    chk("R1 pin_force in reset", 32'(pin_force), 32'd0);
    chk("R1 tctl_q in reset", 32'(tctl_q), 32'd0);
    @(negedge tck); #1;
    trst_n = 1'b1;
  endtask

  initial begin
    logic [5:0] ir_rd;
    logic [31:0] rd;
    #20;
    chk("R1 tdo_oe at reset", 32'(tdo_oe), 32'd0);
    chk("R1 tdo at reset", 32'(tdo), 32'd0);
    chk("R1 controls at reset", {29'd0, pin_force, pin_hiz, core_rst}, 32'd0);
    chk("R1 tctl_q at reset", 32'(tctl_q), 32'd0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(1, 0); step(0, 0);

    // R7 identity read right after reset
    shift_dr(32, 32'h0, rd);
    chk("R7 id word", rd, IDV);

    // R4 capture pattern, R8 bypass
    load_ir(C_BYP, ir_rd);
    chk("R4 ir capture", 32'(ir_rd), 32'h01);
    shift_dr(8, 32'hB3, rd);
    chk("R8 bypass delay", rd & 32'hFF, 32'h66);

    // R8 unlisted codes fall back to bypass
    load_ir(6'b101010, ir_rd);
    shift_dr(5, 32'h1D, rd);
    chk("R8 unlisted 101010", rd & 32'h1F, 32'h1A);
    load_ir(6'b000011, ir_rd);
    shift_dr(3, 32'h7, rd);
    chk("R8 unlisted 000011", rd & 32'h7, 32'h6);

    // R5 and R10 clamp
    load_ir(C_CLP, ir_rd);
    chk("R5 old instr before update", 32'(pre_rst), 32'd0);
    chk("R10 clamp core_rst", 32'(core_rst), 32'd1);
    chk("R10 clamp pin_force", 32'(pin_force), 32'd1);
    shift_dr(4, 32'hF, rd);
    chk("R10 clamp bypass", rd & 32'hF, 32'hE);

    // R10 highz
    load_ir(C_HIZ, ir_rd);
    chk("R10 highz controls", {29'd0, pin_force, pin_hiz, core_rst}, 32'h3);
    chk("R5 ir capture again R4", 32'(ir_rd), 32'h01);

    // R2 four tms-high edges from Shift-DR are not enough, five are
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk("R2 four edges keep instr", 32'(core_rst), 32'd1);
    step(1, 0);
    chk("R2 five edges reset instr", 32'(core_rst), 32'd0);
    step(0, 0);
    shift_dr(32, 32'h0, rd);
    chk("R2 idcode reloaded R7", rd, IDV);

    // R9 R12 extest
    load_ir(C_EXT, ir_rd);
    chk("R9 extest controls", {29'd0, pin_force, pin_hiz, core_rst}, 32'h5);
    shift_dr(BL, 32'h5A6, rd);
    chk("R12 chain capture read", rd & 32'hFFF, 32'(BPAT));
    chk("R12 chain loaded", 32'(chain), 32'h5A6);

    // R9 sample, with pause states exercised
    load_ir(C_SMP, ir_rd);
    chk("R9 sample controls", {29'd0, pin_force, pin_hiz, core_rst}, 32'h0);
    step(1, 0); step(0, 0); step(0, 0);
    step(1, 1); step(0, 0); step(0, 0); step(1, 0); step(0, 1); step(1, 0);
    step(1, 0); step(0, 0);
    shift_dr(BL, 32'h0, rd);
    chk("R12 sample capture read", rd & 32'hFFF, 32'(BPAT));

    // R11 test-control register
    load_ir(C_ENA, ir_rd);
    shift_dr(TW, 32'hA5, rd);
    chk("R11 tctl initial read", rd & 32'hFF, 32'h00);
    chk("R11 tctl updated", 32'(tctl_q), 32'hA5);
    shift_dr(TW, 32'h3C, rd);
    chk("R11 tctl capture", rd & 32'hFF, 32'hA5);
    chk("R11 tctl second", 32'(tctl_q), 32'h3C);
    // exit straight from Capture-DR: no shift, update still copies
    step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    chk("R11 tctl capture-update", 32'(tctl_q), 32'h3C);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R11 tctl cleared in reset R2", 32'(tctl_q), 32'h00);
    step(0, 0);

    // R1 asynchronous reset during clamp
    load_ir(C_CLP, ir_rd);
    chk("R1 clamp active before trst", 32'(core_rst), 32'd1);
    do_trst();
    step(0, 0);
    chk("R1 after trst core_rst", 32'(core_rst), 32'd0);
    shift_dr(32, 32'h0, rd);
    chk("R1 idcode after trst R7", rd, IDV);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule